// File: doc/BRIEF.md
# Command-Sequenced DMA Channel Register Interface

This block is the host-facing register front end of an eight-channel DMA controller. The host reaches it through two byte-wide I/O locations. The function location, at offset 0x18, takes a byte that names a command and a channel. The execute location, at offset 0x1A, then carries that command's operand bytes one access at a time. Each channel keeps a 24-bit address, a 16-bit count that holds the transfer length minus one, a 16-bit I/O port number, a mode byte and a mask flag. A shared status byte holds one terminal-count flag per channel.

Transfers are modelled by a per-channel step input. A step on a ready channel moves its address forward and its count down, in the way a real transfer engine would. A monitor output shows the registers of any one selected channel at all times, so the effect of programming and stepping can be followed cycle by cycle.

Top module: `dma_cmd_regs`

## Requirements
- R1: A write to offset 0x18 loads a command from bits 7:4 and a channel from bits 3:0, and resets the operand byte pointer to zero. Offsets other than 0x18 and 0x1A have no effect. Channel numbers 8 to 15 and the undefined command codes 0x1, 0x8, 0xB, 0xC, 0xE and 0xF change no channel state.
- R2: Command 0x2 (set address) takes three execute writes holding address bits 7:0, then 15:8, then 23:16. Command 0x3 (get address) returns the same three bytes in the same order on successive execute reads.
- R3: Command 0x4 (set count) takes two execute writes, low byte first. Command 0x5 (get count) returns the count low byte and then the high byte. The stored value is the number of transfers minus one.
- R4: Command 0x0 (set port) takes two execute writes, low byte first. Command 0x7 (set mode) takes one byte. The monitor outputs show the address, count, port and mode of the channel selected by mon_ch.
- R5: Command 0x9 masks and command 0xA unmasks the named channel as soon as the function byte is written. ch_ready[n] is high exactly when channel n is unmasked and its mode bit 2 (transfer enable) is set. After reset every channel is masked and all registers are zero.
- R6: A step on a ready channel adds 1 to the address, or 2 when mode bit 6 (16-bit) is set, wrapping at 24 bits. It also subtracts 1 from the count. A step on a channel that is not ready has no effect.
- R7: A step taken with the count at zero sets the count to 0xFFFF, sets status bit n and masks the channel. A stored count N therefore allows N+1 steps.
- R8: Command 0x6 (get status) returns the status byte, with bit n the terminal-count flag of channel n, on its one execute read. That read clears the flags, except for a flag set in the same cycle, which is kept.
- R9: Execute accesses past the command's operand length are ignored. Execute reads return 0x00 past the operand length, while a set or mask command is current, and for channels 8 to 15. Execute writes while a get command is current are ignored.
- R10: Command 0xD (master clear, any channel nibble) masks every channel and zeroes every address, count, port and mode register and the status byte.
- R11: A step is dropped when, in the same cycle, its channel takes a set-command operand write, a mask or unmask command, or a master clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_addr | input | 8 | Host I/O offset |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Host read byte (combinational, valid while io_rd is high) |
| step | input | NCH | Per-channel transfer step request |
| ch_ready | output | NCH | Channel unmasked and transfer-enabled |
| mon_ch | input | CHW | Channel shown on the monitor outputs |
| mon_addr | output | 24 | Address of the monitored channel |
| mon_cnt | output | 16 | Count of the monitored channel |
| mon_port | output | 16 | I/O port of the monitored channel |
| mon_mode | output | 8 | Mode byte of the monitored channel |

## Verification
A byte pointer that slips leaves an operand byte in the wrong field. This shows on mon_addr, mon_cnt or mon_port on the clock after the write, or on io_rdata during the next get read. A wrong mask or mode bit shows on ch_ready in the same cycle as the register holds it. A wrong step is visible on the monitor one clock after the step. A lost or stale terminal-count flag only appears when the host reads status, so the stimulus drives counts to zero and reads status both straight away and in later random traffic.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam int PORT_W = 16;
    localparam int MODE_W = 8;

    localparam logic [3:0] OP_SET_PORT = 4'h0;
    localparam logic [3:0] OP_SET_ADDR = 4'h2;
    localparam logic [3:0] OP_GET_ADDR = 4'h3;
    localparam logic [3:0] OP_SET_CNT  = 4'h4;
    localparam logic [3:0] OP_GET_CNT  = 4'h5;
    localparam logic [3:0] OP_GET_STAT = 4'h6;
    localparam logic [3:0] OP_SET_MODE = 4'h7;
    localparam logic [3:0] OP_MASK     = 4'h9;
    localparam logic [3:0] OP_UNMASK   = 4'hA;
    localparam logic [3:0] OP_MCLR     = 4'hD;

    localparam int MODE_IO_BIT   = 0;
    localparam int MODE_XFER_BIT = 2;
    localparam int MODE_WDIR_BIT = 3;
    localparam int MODE_W16_BIT  = 6;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [PORT_W-1:0] port;
        logic [MODE_W-1:0] mode;
        logic              masked;
    } chan_t;

    function automatic logic [1:0] op_len(input logic [3:0] op);
        case (op)
            OP_SET_ADDR, OP_GET_ADDR:            return 2'd3;
            OP_SET_CNT, OP_GET_CNT, OP_SET_PORT: return 2'd2;
            OP_GET_STAT, OP_SET_MODE:            return 2'd1;
            default:                             return 2'd0;
        endcase
    endfunction

    function automatic logic is_set_op(input logic [3:0] op);
        return (op == OP_SET_PORT) || (op == OP_SET_ADDR) ||
               (op == OP_SET_CNT)  || (op == OP_SET_MODE);
    endfunction

endpackage

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
    import dma_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fn_wr,
    input  logic       exe_acc,
    input  logic [7:0] wdata,
    output logic [3:0] op_q,
    output logic [3:0] ch_q,
    output logic [1:0] idx_q,
    output logic       in_range
);

    typedef struct packed {
        logic [3:0] op;
        logic [3:0] ch;
        logic [1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fn_wr) begin
            s_d.op  = wdata[7:4];
            s_d.ch  = wdata[3:0];
            s_d.idx = 2'd0;
        end else if (exe_acc && (s_q.idx != 2'd3)) begin
            s_d.idx = s_q.idx + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.op  <= OP_MCLR;
            s_q.ch  <= 4'd0;
            s_q.idx <= 2'd0;
        end else begin
            s_q <= s_d;
        end
    end

    assign op_q     = s_q.op;
    assign ch_q     = s_q.ch;
    assign idx_q    = s_q.idx;
    assign in_range = (s_q.idx < op_len(s_q.op));

    assert_ptr_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fn_wr |=> (idx_q == 2'd0));

    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fn_wr && !exe_acc) |=> $stable(idx_q));

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mclr,
    input  logic       mask_set,
    input  logic       mask_clr,
    input  logic       wr_en,
    input  logic [3:0] op,
    input  logic [1:0] idx,
    input  logic [7:0] wdata,
    input  logic       step,
    output chan_t      st,
    output logic       tc,
    output logic       ready
);

    chan_t st_d, st_q;
    logic  take;

    always_comb begin
        st_d = st_q;
        take = step && !st_q.masked && st_q.mode[MODE_XFER_BIT] &&
               !wr_en && !mask_set && !mask_clr && !mclr;
        tc   = take && (st_q.cnt == '0);
        if (mclr) begin
            st_d        = '0;
            st_d.masked = 1'b1;
        end else begin
            if (mask_set) st_d.masked = 1'b1;
            if (mask_clr) st_d.masked = 1'b0;
            if (wr_en) begin
                case (op)
                    OP_SET_ADDR: begin
                        case (idx)
                            2'd0:    st_d.addr[7:0]   = wdata;
                            2'd1:    st_d.addr[15:8]  = wdata;
                            default: st_d.addr[23:16] = wdata;
                        endcase
                    end
                    OP_SET_CNT: begin
                        if (idx == 2'd0) st_d.cnt[7:0]  = wdata;
                        else             st_d.cnt[15:8] = wdata;
                    end
                    OP_SET_PORT: begin
                        if (idx == 2'd0) st_d.port[7:0]  = wdata;
                        else             st_d.port[15:8] = wdata;
                    end
                    OP_SET_MODE: st_d.mode = wdata;
                    default: ;
                endcase
            end
            if (take) begin
                st_d.addr = st_q.addr + (st_q.mode[MODE_W16_BIT] ? ADDR_W'(2) : ADDR_W'(1));
                st_d.cnt  = st_q.cnt - CNT_W'(1);
                if (tc) st_d.masked = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.masked <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign st    = st_q;
    assign ready = !st_q.masked && st_q.mode[MODE_XFER_BIT];

    assert_masked_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.masked && !mclr && !wr_en) |=> ($stable(st_q.addr) && $stable(st_q.cnt)));

    assert_tc_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> (st_q.masked && (st_q.cnt == '1)));

    assert_mclr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (st_q.masked && (st_q.addr == '0) && (st_q.mode == '0)));

    assert_step_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (step && wr_en && (op == OP_SET_MODE)) |=> (st_q.cnt == $past(st_q.cnt)));

endmodule

// File: rtl/dma_cmd_regs.sv
module dma_cmd_regs
    import dma_cmd_pkg::*;
#(
    parameter int         NCH     = 8,
    parameter logic [7:0] FN_OFS  = 8'h18,
    parameter logic [7:0] EXE_OFS = 8'h1A,
    localparam int        CHW     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    input  logic [NCH-1:0]    step,
    output logic [NCH-1:0]    ch_ready,
    input  logic [CHW-1:0]    mon_ch,
    output logic [ADDR_W-1:0] mon_addr,
    output logic [CNT_W-1:0]  mon_cnt,
    output logic [PORT_W-1:0] mon_port,
    output logic [MODE_W-1:0] mon_mode
);

    logic       fn_wr, exe_wr, exe_rd, mclr, ch_ok, set_op;
    logic [3:0] op_q, ch_q;
    logic [1:0] idx_q;
    logic       in_range;
    logic [NCH-1:0] tc_vec;
    chan_t      ch_st [NCH];
    chan_t      sel_st;

    typedef struct packed {
        logic [NCH-1:0] stat;
    } top_t;

    top_t t_d, t_q;

    assign fn_wr  = io_wr && (io_addr == FN_OFS);
    assign exe_wr = io_wr && (io_addr == EXE_OFS);
    assign exe_rd = io_rd && (io_addr == EXE_OFS);
    assign mclr   = fn_wr && (io_wdata[7:4] == OP_MCLR);
    assign ch_ok  = (32'(ch_q) < NCH);
    assign set_op = is_set_op(op_q);

    dma_cmd_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fn_wr    (fn_wr),
        .exe_acc  (exe_wr || exe_rd),
        .wdata    (io_wdata),
        .op_q     (op_q),
        .ch_q     (ch_q),
        .idx_q    (idx_q),
        .in_range (in_range)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit_fn;
        assign hit_fn = fn_wr && (io_wdata[3:0] == 4'(g));
        dma_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mclr     (mclr),
            .mask_set (hit_fn && (io_wdata[7:4] == OP_MASK)),
            .mask_clr (hit_fn && (io_wdata[7:4] == OP_UNMASK)),
            .wr_en    (exe_wr && in_range && set_op && (ch_q == 4'(g))),
            .op       (op_q),
            .idx      (idx_q),
            .wdata    (io_wdata),
            .step     (step[g]),
            .st       (ch_st[g]),
            .tc       (tc_vec[g]),
            .ready    (ch_ready[g])
        );
    end

    always_comb begin
        t_d = t_q;
        if (mclr) begin
            t_d.stat = '0;
        end else begin
            if (exe_rd && in_range && (op_q == OP_GET_STAT)) t_d.stat = '0;
            t_d.stat = t_d.stat | tc_vec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign sel_st = ch_st[ch_q[CHW-1:0]];

    always_comb begin
        io_rdata = 8'h00;
        if (exe_rd && in_range) begin
            case (op_q)
                OP_GET_ADDR: if (ch_ok) begin
                    case (idx_q)
                        2'd0:    io_rdata = sel_st.addr[7:0];
                        2'd1:    io_rdata = sel_st.addr[15:8];
                        default: io_rdata = sel_st.addr[23:16];
                    endcase
                end
                OP_GET_CNT: if (ch_ok) begin
                    io_rdata = (idx_q == 2'd0) ? sel_st.cnt[7:0] : sel_st.cnt[15:8];
                end
                OP_GET_STAT: io_rdata = 8'(t_q.stat);
                default: ;
            endcase
        end
    end

    assign mon_addr = ch_st[mon_ch].addr;
    assign mon_cnt  = ch_st[mon_ch].cnt;
    assign mon_port = ch_st[mon_ch].port;
    assign mon_mode = ch_st[mon_ch].mode;

    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_rd && !in_range) |-> (io_rdata == 8'h00));

    assert_stat_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((|tc_vec) && !mclr) |=> ((t_q.stat & $past(tc_vec)) == $past(tc_vec)));

    assert_mclr_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> ((ch_ready == '0) && (t_q.stat == '0)));

    assert_mask_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fn_wr && (io_wdata[7:4] == OP_MASK) && (32'(io_wdata[3:0]) < NCH))
            |=> (ch_ready == '0 || !ch_ready[$past(io_wdata[2:0])]));

endmodule

// File: tb/test_dma_cmd_regs.sv
module test_dma_cmd_regs;

    localparam logic [7:0] FN  = 8'h18;
    localparam logic [7:0] EXE = 8'h1A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_addr = 8'h00, io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic [7:0]  step = 8'h00;
    logic [7:0]  ch_ready;
    logic [2:0]  mon_ch = 3'd0;
    logic [23:0] mon_addr;
    logic [15:0] mon_cnt, mon_port;
    logic [7:0]  mon_mode;

    int checks = 0, errors = 0, cyc = 0;

    dma_cmd_regs i_dma_cmd_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .step(step), .ch_ready(ch_ready), .mon_ch(mon_ch),
        .mon_addr(mon_addr), .mon_cnt(mon_cnt), .mon_port(mon_port), .mon_mode(mon_mode)
    );

    always #5 clk = ~clk;

    // behavioural reference state
    int unsigned m_addr [8], m_cnt [8], m_port [8], m_mode [8];
    bit          m_mask [8];
    bit [7:0]    m_stat;
    bit [3:0]    m_op, m_ch;
    int          m_idx;

    function automatic int oplen(bit [3:0] op);
        if (op == 4'h2 || op == 4'h3) return 3;
        if (op == 4'h4 || op == 4'h5 || op == 4'h0) return 2;
        if (op == 4'h6 || op == 4'h7) return 1;
        return 0;
    endfunction

    function automatic int exp_read();
        if (m_idx >= oplen(m_op)) return 0;
        if (m_op == 4'h6) return m_stat;
        if (m_ch > 7) return 0;
        if (m_op == 4'h3) return (m_addr[m_ch] >> (8 * m_idx)) & 255;
        if (m_op == 4'h5) return (m_cnt[m_ch] >> (8 * m_idx)) & 255;
        return 0;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_addr[i] = 0; m_cnt[i] = 0; m_port[i] = 0; m_mode[i] = 0; m_mask[i] = 1;
        end
        m_stat = 0;
    endtask

    task automatic model_step();
        bit fnw, exw, exr, inr, setop, mclr, blk, take;
        bit [3:0] opi, chi;
        bit [7:0] nstat;
        fnw = io_wr && io_addr == FN;
        exw = io_wr && io_addr == EXE;
        exr = io_rd && io_addr == EXE;
        opi = io_wdata[7:4];
        chi = io_wdata[3:0];
        inr = m_idx < oplen(m_op);
        setop = (m_op == 4'h0 || m_op == 4'h2 || m_op == 4'h4 || m_op == 4'h7);
        mclr = fnw && opi == 4'hD;
        nstat = m_stat;
        if (exr && inr && m_op == 4'h6) nstat = 0;
        for (int i = 0; i < 8; i++) begin
            blk = mclr || (fnw && chi == 4'(i) && (opi == 4'h9 || opi == 4'hA)) ||
                  (exw && inr && setop && m_ch == 4'(i));
            take = step[i] && !m_mask[i] && m_mode[i][2] && !blk;
            if (take) begin
                m_addr[i] = (m_addr[i] + (m_mode[i][6] ? 2 : 1)) & 32'hFFFFFF;
                if (m_cnt[i] == 0) begin
                    m_cnt[i] = 16'hFFFF; m_mask[i] = 1; nstat[i] = 1'b1;
                end else m_cnt[i] = m_cnt[i] - 1;
            end
        end
        if (fnw && chi < 8 && opi == 4'h9) m_mask[chi] = 1;
        if (fnw && chi < 8 && opi == 4'hA) m_mask[chi] = 0;
        if (exw && inr && setop && m_ch < 8) begin
            case (m_op)
                4'h2: m_addr[m_ch] = (m_addr[m_ch] & ~(32'hFF << (8*m_idx))) | (int'(io_wdata) << (8*m_idx));
                4'h4: m_cnt[m_ch]  = (m_cnt[m_ch]  & ~(32'hFF << (8*m_idx))) | (int'(io_wdata) << (8*m_idx));
                4'h0: m_port[m_ch] = (m_port[m_ch] & ~(32'hFF << (8*m_idx))) | (int'(io_wdata) << (8*m_idx));
                default: m_mode[m_ch] = io_wdata;
            endcase
        end
        m_stat = nstat;
        if (mclr) model_reset();
        if (fnw) begin m_op = opi; m_ch = chi; m_idx = 0; end
        else if ((exw || exr) && m_idx < 3) m_idx++;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // model update at each edge, full comparison shortly after
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            model_reset(); m_op = 4'hD; m_ch = 0; m_idx = 0;
        end else model_step();
        #2;
        if (rst_n) begin
            for (int i = 0; i < 8; i++)
                check("R5 ch_ready", int'(ch_ready[i]), int'(!m_mask[i] && m_mode[i][2]));
            check("R6 mon_addr", int'(mon_addr), int'(m_addr[mon_ch]));
            check("R6 mon_cnt",  int'(mon_cnt),  int'(m_cnt[mon_ch]));
            check("R4 mon_port", int'(mon_port), int'(m_port[mon_ch]));
            check("R4 mon_mode", int'(mon_mode), int'(m_mode[mon_ch]));
        end
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic bus(input bit wr, input bit rd, input logic [7:0] a, input logic [7:0] d,
                       input logic [7:0] stp, input string tag, output int got);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; step = stp;
        #1;
        got = io_rdata;
        if (rd) check(tag, int'(io_rdata), exp_read());
        @(posedge clk);
        #1;
        io_wr = 0; io_rd = 0; step = 0;
    endtask

    task automatic fnw(input logic [7:0] d);
        int g; bus(1, 0, FN, d, 8'h00, "", g);
    endtask
    task automatic exw(input logic [7:0] d);
        int g; bus(1, 0, EXE, d, 8'h00, "", g);
    endtask
    task automatic exr(input string tag, input int lit);
        int g; bus(0, 1, EXE, 8'h00, 8'h00, tag, g);
        if (lit >= 0) check(tag, g, lit);
    endtask
    task automatic stp(input logic [7:0] s);
        int g; bus(0, 0, 8'h00, 8'h00, s, "", g);
    endtask

    initial begin
        int g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset ready", int'(ch_ready), 0);
        check("R5 reset addr", int'(mon_addr), 0);
        fnw(8'h60); exr("R8 status after reset", 0);

        // R2 address write/read order
        mon_ch = 3'd2;
        fnw(8'h22); exw(8'h56); exw(8'h34); exw(8'h12);
        check("R2 addr assembled", int'(mon_addr), 32'h123456);
        fnw(8'h32);
        exr("R2 get addr b0", 8'h56); exr("R2 get addr b1", 8'h34); exr("R2 get addr b2", 8'h12);
        exr("R9 read beyond length", 0);

        // R3 count, with an extra byte ignored (R9)
        fnw(8'h42); exw(8'h02); exw(8'h00); exw(8'hFF);
        check("R9 extra byte ignored", int'(mon_cnt), 2);
        fnw(8'h52); exr("R3 get cnt lo", 2); exr("R3 get cnt hi", 0);

        // R4 port and mode
        fnw(8'h02); exw(8'hCD); exw(8'hAB);
        check("R4 port", int'(mon_port), 16'hABCD);
        fnw(8'h72); exw(8'h44);
        check("R4 mode", int'(mon_mode), 8'h44);
        exr("R9 read during set", 0);

        // R6 masked channel ignores step; R5 unmask
        stp(8'h04);
        check("R6 masked step ignored", int'(mon_addr), 32'h123456);
        fnw(8'hA2);
        check("R5 unmask ready", int'(ch_ready[2]), 1);

        // R6/R7 three word steps from stored count 2
        stp(8'h04); stp(8'h04);
        check("R6 word step addr", int'(mon_addr), 32'h12345A);
        check("R6 step cnt", int'(mon_cnt), 0);
        stp(8'h04);
        check("R7 wrap cnt", int'(mon_cnt), 16'hFFFF);
        check("R7 masked at tc", int'(ch_ready[2]), 0);
        fnw(8'h64); exr("R8 status tc", 8'h04);
        fnw(8'h60); exr("R8 status cleared", 0);

        // R1 out-of-range channel, stray offset, undefined op
        fnw(8'h29); exw(8'h11); exw(8'h22); exw(8'h33);
        fnw(8'h39); exr("R1 channel 9 read", 0);
        mon_ch = 3'd5;
        fnw(8'h75); exw(8'h04); fnw(8'hA5);
        bus(1, 0, 8'h19, 8'hD0, 8'h00, "", g);
        check("R1 stray offset", int'(ch_ready[5]), 1);
        fnw(8'h85); fnw(8'hB5);
        check("R1 undefined op", int'(ch_ready[5]), 1);

        // R6 byte-mode carry across 24 bits, single transfer count
        fnw(8'h25); exw(8'hFF); exw(8'hFF); exw(8'h00);
        stp(8'h20);
        check("R6 byte step carry", int'(mon_addr), 32'h010000);
        check("R7 count zero one step", int'(ch_ready[5]), 0);

        // R11 step dropped on operand write to same channel
        fnw(8'hA5); fnw(8'h45);
        bus(1, 0, EXE, 8'h07, 8'h20, "", g);
        check("R11 step dropped", int'(mon_addr), 32'h010000);
        exw(8'h00);
        stp(8'h20);
        check("R11 later step taken", int'(mon_addr), 32'h010001);
        check("R11 later step cnt", int'(mon_cnt), 6);
        bus(1, 0, FN, 8'h95, 8'h20, "", g);
        check("R11 step dropped on mask", int'(mon_addr), 32'h010001);

        // R10 master clear
        fnw(8'hA5); fnw(8'hD7);
        check("R10 clear ready", int'(ch_ready), 0);
        check("R10 clear addr", int'(mon_addr), 0);
        fnw(8'h60); exr("R10 clear status", 0);

        // random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int k;
            logic [7:0] d;
            k = $urandom_range(0, 99);
            mon_ch = 3'($urandom_range(0, 7));
            if (k < 2) fnw(8'hD0);
            else if (k < 30) begin
                int ops[9] = '{0, 2, 3, 4, 5, 6, 7, 9, 10};
                d = {4'(ops[$urandom_range(0, 8)]), 4'($urandom_range(0, 9))};
                bus(1, 0, FN, d, 8'($urandom_range(0, 255)), "R8 random", g);
            end else if (k < 55) begin
                d = ($urandom_range(0, 1) == 1) ? 8'($urandom_range(0, 3)) : 8'($urandom_range(0, 255));
                if (m_op == 4'h7) d = d | 8'h04;
                bus(1, 0, EXE, d, 8'($urandom_range(0, 255)), "R11 random", g);
            end else if (k < 75) bus(0, 1, EXE, 8'h00, 8'($urandom_range(0, 255)), "R9 random read", g);
            else stp(8'($urandom_range(0, 255)));
        end

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule